// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces one pulse-width-modulated output for a small peripheral. Software programs an 8-bit period limit, a prescale choice and a 10-bit duty value through one byte-wide write port. An 8-bit timer counts up at one step per four system clocks times the prescale factor. Two extra low-order bits refine the timer into a 10-bit time base, so the duty resolution is four times finer than the timer step.

The duty value is held in two byte registers. A format bit selects whether the value is packed to the right or to the left across them. The output only ever uses a shadow copy of the duty value. That copy is refreshed when the timer passes its period limit, and again on the first cycle after enable. A write that lands in the middle of a period therefore cannot cut a pulse short or stretch it.

The pin goes high at the start of each period and drops when the fine time base reaches the shadow duty. A duty of zero never raises the pin. A duty beyond the last reachable count never lowers it.

Top module: `pwm10_dbuf`

## Requirements
- R1: A synchronous active-high `rst` drives the pin low and clears the counters. It sets the period limit to 255, the duty bytes to 0, the prescale code to 0 and the format bit to 0.
- R2: With period limit PR and prescale code S, the output period is (PR+1)·4·P system clocks. P is 1, 4, 16 or 64 for S = 0, 1, 2 or 3 respectively.
- R3: The pin rises at the start of every period. It stays high for D·P system clocks, where D is the buffered duty and 0 < D < 4·(PR+1).
- R4: Control bit 2 is the format bit. With 0, the duty is the high byte bits 1:0 followed by all of the low byte. With 1, it is all of the high byte followed by low byte bits 7:6. The bits that the chosen format does not use have no effect on the output.
- R5: A duty written during a period has no effect on that period's pulse. It first applies to the period that follows the next period-limit rollover.
- R6: A buffered duty of 0 keeps the pin low for the whole period.
- R7: A buffered duty of 4·(PR+1) or more produces no clear event, so the pin stays high.
- R8: While `en` is low, the pin is low and the counters are held at zero. After `en` rises, the duty is loaded at once and, if it is nonzero, the pin is high one clock later.
- R9: A write takes effect at the clock edge where `wr_en` is high. `wr_sel` picks the target: 0 is the period limit, 1 is the duty high byte, 2 is the duty low byte, and 3 is control. In control, bits 1:0 hold the prescale code and bit 2 holds the format bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables counting and the output |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 2 | Register select for a write |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 1 | PWM output pin |

## Verification
The hardest case to reach from the ports is a duty write that arrives while a pulse is in progress. The bench watches the pin to find each period start. It then splits a new duty across two byte writes inside the high phase of the same period, and it measures both that period and the following one. The two ends of the duty range are driven directly: zero, one below the reach, exactly the reach and the full 10-bit maximum. The unused-bit garbage in both formats is driven the same way. Random configurations cover every prescale code, with pulse widths compared against bench formulas.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD  = 2'd0,
    SEL_DUTY_HI = 2'd1,
    SEL_DUTY_LO = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
  import pwm10_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FINE_W = 2,
  parameter int PS_W   = 2,
  localparam int DUTY_W = DATA_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] period_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [PS_W-1:0]   ps_o
);
  logic [DATA_W-1:0] period_q, hi_q, lo_q;
  logic [PS_W-1:0]   ps_q;
  logic              fmt_q;
  reg_sel_e          sel_e;

  assign sel_e = reg_sel_e'(wr_sel);

  // right-packed: few high-byte bits on top of the full low byte
  function automatic logic [DUTY_W-1:0] pack_right(input logic [DATA_W-1:0] hi,
                                                   input logic [DATA_W-1:0] lo);
    return {hi[FINE_W-1:0], lo};
  endfunction

  // left-packed: full high byte on top of the top bits of the low byte
  function automatic logic [DUTY_W-1:0] pack_left(input logic [DATA_W-1:0] hi,
                                                  input logic [DATA_W-1:0] lo);
    return {hi, lo[DATA_W-1 -: FINE_W]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '1;
      hi_q     <= '0;
      lo_q     <= '0;
      ps_q     <= '0;
      fmt_q    <= 1'b0;
    end else if (wr_en) begin
      case (sel_e)
        SEL_PERIOD:  period_q <= wr_data;
        SEL_DUTY_HI: hi_q     <= wr_data;
        SEL_DUTY_LO: lo_q     <= wr_data;
        SEL_CTRL: begin
          ps_q  <= wr_data[PS_W-1:0];
          fmt_q <= wr_data[PS_W];
        end
        default: ;
      endcase
    end
  end

  assign period_o = period_q;
  assign ps_o     = ps_q;
  assign duty_o   = fmt_q ? pack_left(hi_q, lo_q) : pack_right(hi_q, lo_q);
endmodule

// File: rtl/pwm10_prescale.sv
module pwm10_prescale #(
  parameter int FINE_W = 2,
  parameter int PS_W   = 2,
  localparam int NSEL  = 1 << PS_W,
  localparam int CNT_W = FINE_W * NSEL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              run,
  input  logic [PS_W-1:0]   ps_sel,
  output logic              tick,
  output logic [FINE_W-1:0] fine_nxt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // last phase of one timer step: 4^(sel+1) - 1 system clocks
  function automatic logic [CNT_W-1:0] last_phase(input logic [PS_W-1:0] s);
    logic [CNT_W:0] w;
    logic [CNT_W:0] m;
    w = (CNT_W+1)'(1) << (FINE_W * (int'(s) + 1));
    m = w - (CNT_W+1)'(1);
    return m[CNT_W-1:0];
  endfunction

  // sub-step bits: clock phase at 1:1, top prescaler bits otherwise
  function automatic logic [FINE_W-1:0] fine_of(input logic [CNT_W-1:0] c,
                                                input logic [PS_W-1:0]  s);
    logic [CNT_W-1:0] sh;
    sh = c >> (FINE_W * int'(s));
    return sh[FINE_W-1:0];
  endfunction

  assign tick = run && (cnt_q >= last_phase(ps_sel));

  always_comb begin
    if (clear)     cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign fine_nxt = fine_of(cnt_d, ps_sel);
endmodule

// File: rtl/pwm10_timer.sv
module pwm10_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [TMR_W-1:0] period,
  output logic             rollover,
  output logic [TMR_W-1:0] tmr_nxt
);
  logic [TMR_W-1:0] tmr_q;

  assign rollover = tick && (tmr_q == period);

  always_comb begin
    if (clear)         tmr_nxt = '0;
    else if (rollover) tmr_nxt = '0;
    else if (tick)     tmr_nxt = tmr_q + 1'b1;
    else               tmr_nxt = tmr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) tmr_q <= '0;
    else     tmr_q <= tmr_nxt;
  end
endmodule

// File: rtl/pwm10_compare.sv
module pwm10_compare #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [DUTY_W-1:0] duty_req,
  input  logic [DUTY_W-1:0] tb_nxt,
  output logic              pin,
  output logic [DUTY_W-1:0] shadow
);
  logic              pin_q;
  logic [DUTY_W-1:0] shadow_q;
  logic              hit;

  assign hit = (tb_nxt == shadow_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q    <= 1'b0;
      shadow_q <= '0;
    end else begin
      if (load) shadow_q <= duty_req;
      if (!en)       pin_q <= 1'b0;
      else if (load) pin_q <= (duty_req != '0);
      else if (hit)  pin_q <= 1'b0;
    end
  end

  assign pin    = pin_q;
  assign shadow = shadow_q;

  a_r8_low_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pin_q) else $error("pin high while disabled");

  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(shadow_q)) else $error("shadow changed outside a load");

  a_r6_zero_keeps_low: assert property (@(posedge clk) disable iff (rst)
    (load && duty_req == '0) |=> !pin_q) else $error("zero duty raised the pin");

  a_r3_rise_only_at_load: assert property (@(posedge clk) disable iff (rst)
    (!pin_q && !load) |=> !pin_q) else $error("pin rose without a period start");
endmodule

// File: rtl/pwm10_dbuf.sv
module pwm10_dbuf #(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2,
  parameter int PS_W   = 2,
  localparam int DUTY_W = TMR_W + FINE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [TMR_W-1:0] wr_data,
  output logic             pwm_out
);
  logic [TMR_W-1:0]  period;
  logic [DUTY_W-1:0] duty_req, shadow, tb_nxt;
  logic [PS_W-1:0]   ps_sel;
  logic [FINE_W-1:0] fine_nxt;
  logic [TMR_W-1:0]  tmr_nxt;
  logic run_q, start, run, tick, rollover, load;

  // first reachable fine count that lies past the end of a period
  function automatic logic [DUTY_W:0] reach_of(input logic [TMR_W-1:0] p);
    logic [DUTY_W:0] r;
    r = (DUTY_W+1)'(p) + (DUTY_W+1)'(1);
    return r << FINE_W;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= en;
  end

  assign start  = en && !run_q;
  assign run    = en && run_q;
  assign load   = start || rollover;
  assign tb_nxt = {tmr_nxt, fine_nxt};

  pwm10_regs #(.DATA_W(TMR_W), .FINE_W(FINE_W), .PS_W(PS_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .period_o(period), .duty_o(duty_req), .ps_o(ps_sel)
  );

  pwm10_prescale #(.FINE_W(FINE_W), .PS_W(PS_W)) u_prescale (
    .clk(clk), .rst(rst), .clear(!en), .run(run), .ps_sel(ps_sel),
    .tick(tick), .fine_nxt(fine_nxt)
  );

  pwm10_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .clear(!en), .tick(tick), .period(period),
    .rollover(rollover), .tmr_nxt(tmr_nxt)
  );

  pwm10_compare #(.DUTY_W(DUTY_W)) u_compare (
    .clk(clk), .rst(rst), .en(en), .load(load), .duty_req(duty_req),
    .tb_nxt(tb_nxt), .pin(pwm_out), .shadow(shadow)
  );

  a_r8_start_sets_pin: assert property (@(posedge clk) disable iff (rst)
    (start && duty_req != '0) |=> pwm_out) else $error("enable did not start a pulse");

  a_r7_no_clear_past_reach: assert property (@(posedge clk) disable iff (rst)
    (run && !load && pwm_out && ({1'b0, shadow} >= reach_of(period))) |=> pwm_out)
    else $error("pin cleared by an unreachable duty");
endmodule

// File: tb/test_pwm10_dbuf.sv
module test_pwm10_dbuf;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic pwm_out;

  always #10 clk = ~clk;

  pwm10_dbuf i_pwm10_dbuf (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  int checks = 0, failures = 0;
  bit prev_pin = 1'b0, seen = 1'b0;
  int hi_acc = 0, per_acc = 0, last_hi = 0, last_per = 0, n_periods = 0;

  // edge monitor: measures each full period from rise to rise
  always @(negedge clk) begin
    if (!rst) begin
      if (pwm_out && !prev_pin) begin
        if (seen) begin
          last_hi = hi_acc; last_per = per_acc; n_periods = n_periods + 1;
        end
        seen = 1'b1; hi_acc = 1; per_acc = 1;
      end else if (seen) begin
        per_acc = per_acc + 1;
        if (pwm_out) hi_acc = hi_acc + 1;
      end
      prev_pin = pwm_out;
    end
  end

  function automatic int exp_per(int pr, int ps);
    return (pr + 1) * 4 * (1 << (2 * ps));
  endfunction

  function automatic int exp_hi(int d, int ps);
    return d * (1 << (2 * ps));
  endfunction

  task automatic check_eq(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // R4 packing rules, with garbage in the bits a format ignores
  task automatic load_duty(input int d, input bit fmt, input bit junk);
    logic [7:0] hi, lo;
    if (!fmt) begin
      hi = 8'(d >> 8); lo = 8'(d);
      if (junk) hi = hi | 8'hFC;
    end else begin
      hi = 8'(d >> 2); lo = 8'((d & 3) << 6);
      if (junk) lo = lo | 8'h3F;
    end
    write_reg(2'd1, hi);
    write_reg(2'd2, lo);
  endtask

  task automatic setup(input int pr, input int ps, input bit fmt, input int d, input bit junk);
    @(negedge clk); en = 1'b0;
    @(negedge clk); @(negedge clk);
    seen = 1'b0; n_periods = 0;
    write_reg(2'd3, {5'b0, fmt, 2'(ps)});
    write_reg(2'd0, 8'(pr));
    load_duty(d, fmt, junk);
    @(negedge clk); en = 1'b1;
  endtask

  task automatic count_high(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) cnt++;
    end
  endtask

  task automatic run_case(input int pr, input int ps, input bit fmt, input int d,
                          input bit junk, input string tag);
    setup(pr, ps, fmt, d, junk);
    wait (n_periods >= 1);
    check_eq(last_per, exp_per(pr, ps), {tag, " period R2 R9"});
    check_eq(last_hi, exp_hi(d, ps), {tag, " high R3"});
    wait (n_periods >= 2);
    check_eq(last_per, exp_per(pr, ps), {tag, " period2 R2"});
    check_eq(last_hi, exp_hi(d, ps), {tag, " high2 R3"});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq(int'(pwm_out), 0, "R1 pin after reset");

    // R1 defaults: period limit 255, prescale 1, right format
    load_duty(100, 1'b0, 1'b0);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    check_eq(int'(pwm_out), 1, "R8 pin one clock after enable");
    wait (n_periods >= 1);
    check_eq(last_per, 1024, "R1 default period");
    check_eq(last_hi, 100, "R1 default high");

    // R8: disable mid-pulse, then hold off while configured
    en = 1'b0;
    @(negedge clk);
    check_eq(int'(pwm_out), 0, "R8 pin low after disable");
    count_high(40, cnt);
    check_eq(cnt, 0, "R8 disabled window");

    // R2 / R3 directed, every prescale code and the smallest period
    run_case(9, 0, 1'b0, 17, 1'b0, "R3 pr9 p1");
    run_case(3, 1, 1'b0, 5, 1'b0, "R2 pr3 p4");
    run_case(2, 2, 1'b0, 7, 1'b0, "R2 pr2 p16");
    run_case(1, 3, 1'b0, 3, 1'b0, "R2 pr1 p64");
    run_case(0, 0, 1'b0, 1, 1'b0, "R3 pr0 d1");
    run_case(0, 0, 1'b0, 3, 1'b0, "R3 pr0 d3");
    run_case(9, 0, 1'b0, 39, 1'b0, "R7 one below reach");

    // R4 format and ignored bits
    run_case(255, 0, 1'b1, 693, 1'b0, "R4 left format");
    run_case(20, 0, 1'b0, 50, 1'b1, "R4 right junk");
    run_case(20, 1, 1'b1, 61, 1'b1, "R4 left junk");

    // R5 mid-period write
    setup(9, 0, 1'b0, 10, 1'b0);
    wait (n_periods >= 1);
    check_eq(last_hi, 10, "R5 before write");
    load_duty(25, 1'b0, 1'b0);
    wait (n_periods >= 2);
    check_eq(last_hi, 10, "R5 period of the write");
    wait (n_periods >= 3);
    check_eq(last_hi, 25, "R5 following period");

    // R6 zero duty
    setup(9, 0, 1'b0, 0, 1'b0);
    count_high(120, cnt);
    check_eq(cnt, 0, "R6 zero right");
    setup(4, 1, 1'b1, 0, 1'b1);
    count_high(200, cnt);
    check_eq(cnt, 0, "R6 zero left junk");

    // R7 unreachable duty
    setup(9, 0, 1'b0, 40, 1'b0);
    count_high(120, cnt);
    check_eq(cnt, 120, "R7 duty equals reach");
    setup(200, 0, 1'b1, 1023, 1'b0);
    count_high(300, cnt);
    check_eq(cnt, 300, "R7 full-scale duty");

    // random configurations
    for (int i = 0; i < 12; i++) begin
      int ps, pr, d;
      bit fmt, junk;
      ps   = $urandom_range(0, 3);
      pr   = (ps == 3) ? $urandom_range(0, 7) : $urandom_range(0, 31);
      d    = $urandom_range(1, 4 * (pr + 1) - 1);
      fmt  = 1'($urandom_range(0, 1));
      junk = 1'($urandom_range(0, 1));
      run_case(pr, ps, fmt, d, junk, "R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule